// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address in the first fetch stage, before the instruction has been decoded. It keeps a direct-mapped table of 2^IDX_W entries. Each entry holds a valid bit, the complete branch address used as a tag, a predicted target and a two-bit saturating counter. A fetch address whose table slot holds a matching, valid entry with a counter in the taken half is redirected to the stored target. Every other fetch address continues at PC+4.

The execute stage reports each resolved instruction on a resolution port. Only control transfers change the table. A taken transfer that misses is installed. A resolved branch that hits moves its counter, and a taken one refreshes its target. An entry whose counter falls to zero is dropped. Instructions that are not control transfers never allocate, so ordinary ALU instructions cannot produce false redirects.

The execute stage also returns the next PC that was predicted for the resolved instruction. When that value differs from the real next PC, the block raises a one-cycle kill request together with the corrected fetch address. Flushing the pipeline is left to the surrounding logic.

Top module: `btb_direct`

## Requirements
- R1: After reset every entry is invalid, so every fetch address predicts fetch_pc+4.
- R2: The slot is selected by fetch_pc[IDX_W+1:2]. If that slot is invalid, or its stored address differs from fetch_pc in any bit, pred_npc is fetch_pc+4.
- R3: If the slot is valid, its stored address equals fetch_pc and its counter bit 1 is set (counter value 2 or 3), pred_npc is the stored target.
- R4: A resolution with res_ctrl low never changes the table.
- R5: A taken control resolution that misses installs an entry with the branch address, res_target and counter 2 (weakly taken). A not-taken resolution that misses installs nothing.
- R6: A control resolution that hits updates the counter, with 0 meaning strongly not-taken and 3 meaning strongly taken. A taken outcome increments it, saturating at 3, and rewrites the target with res_target. A not-taken outcome decrements it, and an entry that reaches 0 is invalidated.
- R7: For a control resolution, the actual next PC is res_target if taken and res_pc+4 otherwise. If this differs from res_pred_npc, kill is high in the following cycle only, and redirect_pc then holds the actual next PC.
- R8: A control resolution whose actual next PC equals res_pred_npc, and any non-control resolution, leaves kill low in the following cycle.
- R9: A lookup in the same cycle as a resolution that writes the same slot returns the contents the slot had before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| fetch_pc | input | PC_W | Address being fetched |
| pred_npc | output | PC_W | Predicted next fetch address (combinational) |
| res_valid | input | 1 | A resolved instruction is presented |
| res_ctrl | input | 1 | The resolved instruction is a control transfer |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_taken | input | 1 | Resolved direction |
| res_target | input | PC_W | Resolved target address |
| res_pred_npc | input | PC_W | Next PC that was predicted for this instruction |
| kill | output | 1 | One-cycle misprediction kill request |
| redirect_pc | output | PC_W | Corrected fetch address, valid while kill is high |

## Verification
Two functions can fall in the same cycle: the fetch-side lookup and the execute-side write to the same slot. The bench provokes this on every resolution it issues by placing fetch_pc on res_pc while the resolution is presented. It judges the lookup against the slot contents from before the write, as R9 requires, and then judges kill and redirect_pc one clock later. A long pseudo-random run confines its addresses to a few tags per slot, which forces aliasing, allocation, hysteresis and invalidation to interleave.

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int IDX_W = 7,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  input  logic            res_valid,
  input  logic            res_ctrl,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_npc,
  output logic            kill,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic            vld_q [DEPTH];
  logic [PC_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0] tgt_q [DEPTH];
  logic [1:0]      cnt_q [DEPTH];

  logic [IDX_W-1:0] f_idx, r_idx;
  logic             f_hit, r_hit;
  logic [PC_W-1:0]  act_npc;
  logic             mispred;
  logic             wr_en, wr_vld;
  logic [1:0]       wr_cnt;
  logic [PC_W-1:0]  wr_tgt;
  logic             kill_q;
  logic [PC_W-1:0]  redir_q;

  assign f_idx    = fetch_pc[IDX_W+1:2];
  assign f_hit    = vld_q[f_idx] && (tag_q[f_idx] == fetch_pc);
  assign pred_npc = (f_hit && cnt_q[f_idx][1]) ? tgt_q[f_idx] : fetch_pc + STEP;

  assign r_idx    = res_pc[IDX_W+1:2];
  assign r_hit    = vld_q[r_idx] && (tag_q[r_idx] == res_pc);
  assign act_npc  = res_taken ? res_target : res_pc + STEP;
  assign mispred  = act_npc != res_pred_npc;

  always_comb begin
    wr_en  = 1'b0;
    wr_vld = vld_q[r_idx];
    wr_cnt = cnt_q[r_idx];
    wr_tgt = tgt_q[r_idx];
    if (res_valid && res_ctrl) begin
      if (r_hit) begin
        wr_en = 1'b1;
        if (res_taken) begin
          wr_cnt = (cnt_q[r_idx] == 2'd3) ? 2'd3 : cnt_q[r_idx] + 2'd1;
          wr_tgt = res_target;
          wr_vld = 1'b1;
        end else begin
          wr_cnt = (cnt_q[r_idx] == 2'd0) ? 2'd0 : cnt_q[r_idx] - 2'd1;
          wr_vld = wr_cnt != 2'd0;
        end
      end else if (res_taken) begin
        wr_en  = 1'b1;
        wr_vld = 1'b1;
        wr_cnt = 2'd2;
        wr_tgt = res_target;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else if (wr_en) begin
      vld_q[r_idx] <= wr_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[r_idx] <= res_pc;
      tgt_q[r_idx] <= wr_tgt;
      cnt_q[r_idx] <= wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q  <= 1'b0;
      redir_q <= '0;
    end else begin
      kill_q  <= res_valid && res_ctrl && mispred;
      redir_q <= act_npc;
    end
  end

  assign kill        = kill_q;
  assign redirect_pc = redir_q;

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !f_hit |-> pred_npc == fetch_pc + STEP); // R2
  AST_NONCTRL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ctrl) |-> !wr_en); // R4
  AST_HIT_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && r_hit) |-> cnt_q[r_idx] != 2'd0); // R6
  AST_KILL_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> $past(res_valid && res_ctrl)); // R7
  AST_REDIRECT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> redirect_pc == ($past(res_taken) ? $past(res_target) : $past(res_pc) + STEP)); // R7
  AST_CORRECT_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ctrl && act_npc == res_pred_npc) |=> !kill); // R8
endmodule

// File: tb/tb_btb_direct.sv
`timescale 1ns/1ps
module tb_btb_direct;
  localparam int IW = 3;
  localparam int PW = 32;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] fetch_pc = '0;
  logic [PW-1:0] pred_npc;
  logic          res_valid = 1'b0, res_ctrl = 1'b0, res_taken = 1'b0;
  logic [PW-1:0] res_pc = '0, res_target = '0, res_pred_npc = '0;
  logic          kill;
  logic [PW-1:0] redirect_pc;

  always #2.5 clk = ~clk;

  btb_direct #(.IDX_W(IW), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
    .res_valid(res_valid), .res_ctrl(res_ctrl), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_pred_npc(res_pred_npc),
    .kill(kill), .redirect_pc(redirect_pc));

  bit            m_vld [N];
  logic [PW-1:0] m_pc  [N];
  logic [PW-1:0] m_tgt [N];
  logic [1:0]    m_cnt [N];
  int n_chk = 0, n_fail = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'h1d2c3b4a;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  function automatic logic [PW-1:0] m_pred(input logic [PW-1:0] pc);
    int i;
    i = int'(pc[IW+1:2]);
    if (m_vld[i] && m_pc[i] == pc && m_cnt[i][1]) return m_tgt[i];
    return pc + 4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic look(input logic [PW-1:0] pc, input logic [PW-1:0] exp, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk(pred_npc == exp, req, pred_npc, exp);
  endtask

  task automatic resolve(input bit ctrl, input logic [PW-1:0] pc, input bit taken,
                         input logic [PW-1:0] tgt, input string req);
    logic [PW-1:0] pnpc, act;
    bit expk, hit;
    int i;
    @(negedge clk);
    pnpc = m_pred(pc);
    act  = taken ? tgt : pc + 4;
    expk = ctrl && (act != pnpc);
    fetch_pc = pc; res_valid = 1'b1; res_ctrl = ctrl; res_pc = pc;
    res_taken = taken; res_target = tgt; res_pred_npc = pnpc;
    #1;
    chk(pred_npc == pnpc, "R9 same-cycle lookup sees old entry", pred_npc, pnpc);
    i = int'(pc[IW+1:2]);
    hit = m_vld[i] && m_pc[i] == pc;
    if (ctrl) begin
      if (hit) begin
        if (taken) begin
          if (m_cnt[i] != 2'd3) m_cnt[i] = m_cnt[i] + 2'd1;
          m_tgt[i] = tgt;
        end else begin
          m_cnt[i] = m_cnt[i] - 2'd1;
          if (m_cnt[i] == 2'd0) m_vld[i] = 1'b0;
        end
      end else if (taken) begin
        m_vld[i] = 1'b1; m_pc[i] = pc; m_tgt[i] = tgt; m_cnt[i] = 2'd2;
      end
    end
    @(negedge clk);
    res_valid = 1'b0;
    chk(kill == expk, expk ? {req, " R7 kill"} : {req, " R8 no kill"}, PW'(kill), PW'(expk));
    if (expk) chk(redirect_pc == act, {req, " R7 redirect"}, redirect_pc, act);
    @(negedge clk);
    chk(kill == 1'b0, "R7 kill lasts one cycle", PW'(kill), '0);
  endtask

  initial begin
    do_reset();
    for (int p = 0; p < 4 * N; p++)
      look(32'h100 + 4 * p, 32'h104 + 4 * p, "R1 reset predicts pc+4");

    resolve(1, 32'h100, 1, 32'h400, "R5 taken miss allocates");
    look(32'h100, 32'h400, "R3 hit taken gives target");
    resolve(0, 32'h104, 1, 32'h800, "R4 non-control");
    look(32'h104, 32'h108, "R4 non-control does not allocate");
    resolve(1, 32'h108, 0, 32'h900, "R5 not-taken miss");
    look(32'h108, 32'h10c, "R5 not-taken miss does not allocate");
    look(32'h100 + 4 * N, 32'h104 + 4 * N, "R2 aliased address misses");
    resolve(1, 32'h100, 0, 32'h0, "R6 taken->weak not-taken");
    look(32'h100, 32'h104, "R6 counter 1 predicts pc+4");
    resolve(1, 32'h100, 1, 32'h400, "R6 back to weak taken");
    look(32'h100, 32'h400, "R6 counter 2 predicts target");
    resolve(1, 32'h100, 1, 32'h400, "R8 correct taken");
    resolve(1, 32'h100, 1, 32'h500, "R6 target rewrite");
    look(32'h100, 32'h500, "R6 new target used");
    resolve(1, 32'h100, 0, 32'h0, "R6 3->2");
    resolve(1, 32'h100, 0, 32'h0, "R6 2->1");
    resolve(1, 32'h100, 0, 32'h0, "R6 1->0 invalidates");
    resolve(1, 32'h100, 1, 32'h600, "R6 reinstall after invalidate");
    look(32'h100, 32'h600, "R6 invalidated entry reinstalled at counter 2");

    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic [PW-1:0] pc, tgt;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      pc  = 32'h2000 + {24'h0, lfsr[4:0], 2'b00};
      tgt = 32'h8000 + {28'h0, lfsr[9:8], 2'b00};
      resolve(lfsr[15:13] != 3'd0, pc, lfsr[12] | lfsr[11], tgt, "sweep");
    end
    for (int p = 0; p < 32; p++)
      look(32'h2000 + 4 * p, m_pred(32'h2000 + 4 * p), "R2/R3 sweep lookup");

    do_reset();
    for (int p = 0; p < 32; p++)
      look(32'h2000 + 4 * p, 32'h2004 + 4 * p, "R1 reset clears entries");
    summary();
  end
endmodule